// File: doc/BRIEF.md
# Egress fabric grant scheduler

This block sits in the egress leaf of a scheduled switch fabric. Ingress switches send it requests to transmit data toward its output queues. Each request names the source, the target queue, a traffic class and a packet count. The block holds one pending request per source. Each cycle it picks at most one request to grant, and it answers with a grant that names the source, the queue and the count.

A grant is issued only when two conditions hold. First, the shallow output buffer must have enough free credit to absorb the granted packets. Second, a token bucket must hold enough tokens so that the released data cannot exceed the egress link rate. Credit is reserved when the grant goes out and is returned when the output reports drained packets. Metering happens at request time, so no data enters the fabric without a place to land.

Classes are served in strict priority, and sources within a class are served round-robin. A request that cannot be granted stays in the table until it can be.

Top module: `egress_grant_sched`

## Requirements
- R1: During reset and in the first cycle after it, `gnt_valid` is 0. No pending requests are held after reset.
- R2: A request accepted at a clock edge whose grant condition holds appears on the grant outputs exactly one edge later, carrying the request's source, queue and count, for one cycle.
- R3: Class 0 is the highest priority. A pending class-0 request is always chosen before any class-1 request.
- R4: Within a class, sources are chosen round-robin. Each class keeps a pointer that starts at source 0 after reset and moves to the granted source plus one, wrapping modulo the source count. The search starts at the pointer.
- R5: A request is granted only if its count is at most `BUF_DEPTH` minus the reserved credit. Granting reserves its count. A request that does not fit stays pending and is granted once enough credit is returned.
- R6: `drain_valid` returns `drain_cnt` packets of credit. A return larger than the reserved credit leaves the reserved credit at zero.
- R7: A request is granted only if its count is at most the current token level. Every `WIN` cycles the level gains `cfg_rate`. It is never above `cfg_burst`, and it is clipped to `cfg_burst` every cycle. A grant removes its count. The level is 0 after reset.
- R8: At most one grant is issued per cycle. Each accepted request is granted exactly once, so the same source is never granted in two consecutive cycles.
- R9: A request whose source already holds a pending entry is ignored, including its queue and count. A request with a zero count is ignored.
- R10: Selection is strictly by priority. While the selected higher-class request is blocked by credit or tokens, no lower-class request is granted, even one that would fit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_src | input | $clog2(NSRC) | Requesting ingress source |
| req_queue | input | QW | Target output queue |
| req_cls | input | max(1,$clog2(NCLS)) | Traffic class, 0 highest |
| req_cnt | input | NW | Packets requested |
| drain_valid | input | 1 | Output drain strobe |
| drain_cnt | input | $clog2(BUF_DEPTH+1) | Packets that left the output buffer |
| cfg_rate | input | TOK_W | Tokens added per window |
| cfg_burst | input | TOK_W | Token bucket ceiling |
| gnt_valid | output | 1 | Grant strobe |
| gnt_src | output | $clog2(NSRC) | Granted source |
| gnt_queue | output | QW | Granted queue |
| gnt_cnt | output | NW | Granted packet count |

## Verification
A request driven before an edge is captured at that edge, and its grant is registered at the next edge. The bench checks the ports at the falling edge one cycle after capture, and checks that the strobe has dropped one cycle after that. Blocked requests depend on credit returns and on the window tick, whose phase is not visible at the ports. For these the bench waits a bounded number of cycles that covers a full window plus the two register stages, and then compares the order of the recorded grants. For cases that must not produce a grant, the bench counts grants over a window longer than one token period.

// File: rtl/egs_pkg.sv
package egs_pkg;
  localparam int unsigned DEF_SRC   = 4;
  localparam int unsigned DEF_CLS   = 2;
  localparam int unsigned DEF_QW    = 3;
  localparam int unsigned DEF_NW    = 4;
  localparam int unsigned DEF_DEPTH = 16;
  localparam int unsigned DEF_TW    = 8;
  localparam int unsigned DEF_WIN   = 8;

  // (a + b) modulo m, for a, b < m
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned m);
    int unsigned s;
    s = a + b;
    return (s >= m) ? s - m : s;
  endfunction
endpackage

// File: rtl/egs_req_table.sv
module egs_req_table #(
  parameter int unsigned NSRC = 4,
  parameter int unsigned CLW  = 1,
  parameter int unsigned QW   = 3,
  parameter int unsigned NW   = 4,
  localparam int unsigned SW  = $clog2(NSRC)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [SW-1:0]                  wr_src,
  input  logic [CLW-1:0]                 wr_cls,
  input  logic [QW-1:0]                  wr_q,
  input  logic [NW-1:0]                  wr_cnt,
  input  logic                           clr_en,
  input  logic [SW-1:0]                  clr_src,
  output logic [NSRC-1:0]                pend,
  output logic [NSRC-1:0][CLW-1:0]       cls_tab,
  output logic [NSRC-1:0][QW-1:0]        q_tab,
  output logic [NSRC-1:0][NW-1:0]        cnt_tab
);
  for (genvar i = 0; i < NSRC; i++) begin : g_ent
    logic take;
    assign take = wr_en && (wr_src == SW'(i)) && (wr_cnt != '0) && !pend[i];

    always_ff @(posedge clk) begin
      if (rst)                                pend[i] <= 1'b0;
      else if (clr_en && clr_src == SW'(i))   pend[i] <= 1'b0;
      else if (take)                          pend[i] <= 1'b1;
    end

    // payload fields carry no reset
    always_ff @(posedge clk) begin
      if (take) begin
        cls_tab[i] <= wr_cls;
        q_tab[i]   <= wr_q;
        cnt_tab[i] <= wr_cnt;
      end
    end
  end
endmodule

// File: rtl/egs_arbiter.sv
module egs_arbiter #(
  parameter int unsigned NSRC = 4,
  parameter int unsigned NCLS = 2,
  localparam int unsigned SW  = $clog2(NSRC),
  localparam int unsigned CLW = (NCLS > 1) ? $clog2(NCLS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSRC-1:0]          pend,
  input  logic [NSRC-1:0][CLW-1:0] cls_tab,
  input  logic                     fire,
  output logic                     sel_valid,
  output logic [SW-1:0]            sel_src,
  output logic [CLW-1:0]           sel_cls
);
  logic [NCLS-1:0][SW-1:0] ptr;

  // scan downward so the lowest class and the nearest source win
  always_comb begin
    sel_valid = 1'b0;
    sel_src   = '0;
    sel_cls   = '0;
    for (int c = NCLS - 1; c >= 0; c--) begin
      for (int k = NSRC - 1; k >= 0; k--) begin
        if (pend[egs_pkg::wrap_add(int'(ptr[c]), k, NSRC)] &&
            cls_tab[egs_pkg::wrap_add(int'(ptr[c]), k, NSRC)] == CLW'(c)) begin
          sel_valid = 1'b1;
          sel_src   = SW'(egs_pkg::wrap_add(int'(ptr[c]), k, NSRC));
          sel_cls   = CLW'(c);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (fire) ptr[sel_cls] <= SW'(egs_pkg::wrap_add(int'(sel_src), 1, NSRC));
  end
endmodule

// File: rtl/egs_token_bucket.sv
module egs_token_bucket #(
  parameter int unsigned TW  = 8,
  parameter int unsigned WIN = 8,
  localparam int unsigned WW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] cfg_rate,
  input  logic [TW-1:0] cfg_burst,
  input  logic          use_en,
  input  logic [TW-1:0] use_amt,
  output logic [TW-1:0] tokens
);
  logic [WW-1:0] win_cnt;
  logic          tick;
  int            tok_sum;

  assign tick = (win_cnt == WW'(WIN - 1));

  always_comb begin
    tok_sum = int'(tokens) - (use_en ? int'(use_amt) : 0) + (tick ? int'(cfg_rate) : 0);
    if (tok_sum > int'(cfg_burst)) tok_sum = int'(cfg_burst);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      tokens  <= '0;
    end else begin
      win_cnt <= tick ? '0 : win_cnt + 1'b1;
      tokens  <= TW'(tok_sum);
    end
  end
endmodule

// File: rtl/egress_grant_sched.sv
module egress_grant_sched #(
  parameter int unsigned NSRC      = egs_pkg::DEF_SRC,
  parameter int unsigned NCLS      = egs_pkg::DEF_CLS,
  parameter int unsigned QW        = egs_pkg::DEF_QW,
  parameter int unsigned NW        = egs_pkg::DEF_NW,
  parameter int unsigned BUF_DEPTH = egs_pkg::DEF_DEPTH,
  parameter int unsigned TOK_W     = egs_pkg::DEF_TW,
  parameter int unsigned WIN       = egs_pkg::DEF_WIN,
  localparam int unsigned SW  = $clog2(NSRC),
  localparam int unsigned CLW = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int unsigned RW  = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [SW-1:0]    req_src,
  input  logic [QW-1:0]    req_queue,
  input  logic [CLW-1:0]   req_cls,
  input  logic [NW-1:0]    req_cnt,
  input  logic             drain_valid,
  input  logic [RW-1:0]    drain_cnt,
  input  logic [TOK_W-1:0] cfg_rate,
  input  logic [TOK_W-1:0] cfg_burst,
  output logic             gnt_valid,
  output logic [SW-1:0]    gnt_src,
  output logic [QW-1:0]    gnt_queue,
  output logic [NW-1:0]    gnt_cnt
);
  logic [NSRC-1:0]          pend;
  logic [NSRC-1:0][CLW-1:0] cls_tab;
  logic [NSRC-1:0][QW-1:0]  q_tab;
  logic [NSRC-1:0][NW-1:0]  cnt_tab;
  logic                     sel_valid, fire;
  logic [SW-1:0]            sel_src;
  logic [CLW-1:0]           sel_cls;
  logic [NW-1:0]            sel_cnt;
  logic [TOK_W-1:0]         tokens;
  logic [RW-1:0]            reserved;
  int                       res_sum;

  egs_req_table #(.NSRC(NSRC), .CLW(CLW), .QW(QW), .NW(NW)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(req_valid), .wr_src(req_src), .wr_cls(req_cls), .wr_q(req_queue), .wr_cnt(req_cnt),
    .clr_en(fire), .clr_src(sel_src),
    .pend(pend), .cls_tab(cls_tab), .q_tab(q_tab), .cnt_tab(cnt_tab)
  );

  egs_arbiter #(.NSRC(NSRC), .NCLS(NCLS)) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .cls_tab(cls_tab), .fire(fire),
    .sel_valid(sel_valid), .sel_src(sel_src), .sel_cls(sel_cls)
  );

  egs_token_bucket #(.TW(TOK_W), .WIN(WIN)) u_bucket (
    .clk(clk), .rst(rst), .cfg_rate(cfg_rate), .cfg_burst(cfg_burst),
    .use_en(fire), .use_amt(TOK_W'(sel_cnt)), .tokens(tokens)
  );

  assign sel_cnt = cnt_tab[sel_src];
  assign fire = sel_valid
             && int'(sel_cnt) <= int'(BUF_DEPTH) - int'(reserved)
             && int'(sel_cnt) <= int'(tokens);

  always_comb begin
    res_sum = int'(reserved) + (fire ? int'(sel_cnt) : 0) - (drain_valid ? int'(drain_cnt) : 0);
    if (res_sum < 0) res_sum = 0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reserved  <= '0;
      gnt_valid <= 1'b0;
      gnt_src   <= '0;
      gnt_queue <= '0;
      gnt_cnt   <= '0;
    end else begin
      reserved  <= RW'(res_sum);
      gnt_valid <= fire;
      if (fire) begin
        gnt_src   <= sel_src;
        gnt_queue <= q_tab[sel_src];
        gnt_cnt   <= sel_cnt;
      end
    end
  end
endmodule

// File: rtl/egress_grant_sched_chk.sv
module egress_grant_sched_chk #(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TW    = 8,
  localparam int unsigned SW   = $clog2(NSRC),
  localparam int unsigned RW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            gnt_valid,
  input logic [SW-1:0]   gnt_src,
  input logic [NSRC-1:0] pend,
  input logic [RW-1:0]   reserved,
  input logic [TW-1:0]   tokens,
  input logic [TW-1:0]   cfg_burst
);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !gnt_valid);

  a_r2_entry_released: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> !pend[gnt_src]);

  a_r5_credit_bound: assert property (@(posedge clk) disable iff (rst)
    int'(reserved) <= int'(DEPTH));

  a_r7_token_cap: assert property (@(posedge clk) disable iff (rst)
    tokens <= $past(cfg_burst));

  a_r8_no_repeat_src: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && $past(gnt_valid)) |-> gnt_src != $past(gnt_src));
endmodule

bind egress_grant_sched egress_grant_sched_chk #(.NSRC(NSRC), .DEPTH(BUF_DEPTH), .TW(TOK_W)) u_chk (
  .clk(clk), .rst(rst), .gnt_valid(gnt_valid), .gnt_src(gnt_src), .pend(pend),
  .reserved(reserved), .tokens(tokens), .cfg_burst(cfg_burst)
);

// File: tb/egress_grant_sched_bench.sv
`timescale 1ns/1ps
module egress_grant_sched_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_src = '0;
  logic [2:0] req_queue = '0;
  logic [0:0] req_cls = '0;
  logic [3:0] req_cnt = '0;
  logic       drain_valid = 1'b0;
  logic [4:0] drain_cnt = '0;
  logic [7:0] cfg_rate = '0;
  logic [7:0] cfg_burst = '0;
  logic       gnt_valid;
  logic [1:0] gnt_src;
  logic [2:0] gnt_queue;
  logic [3:0] gnt_cnt;

  int total = 0;
  int bad = 0;
  int g_num = 0;
  int g_src [0:255];
  int g_q   [0:255];
  int g_cnt [0:255];

  always #2.5 clk = ~clk;

  egress_grant_sched u_egress_grant_sched (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src), .req_queue(req_queue),
    .req_cls(req_cls), .req_cnt(req_cnt), .drain_valid(drain_valid), .drain_cnt(drain_cnt),
    .cfg_rate(cfg_rate), .cfg_burst(cfg_burst), .gnt_valid(gnt_valid), .gnt_src(gnt_src),
    .gnt_queue(gnt_queue), .gnt_cnt(gnt_cnt)
  );

  always @(negedge clk) begin
    if (!rst && gnt_valid) begin
      if (g_num < 256) begin
        g_src[g_num] = int'(gnt_src);
        g_q[g_num]   = int'(gnt_queue);
        g_cnt[g_num] = int'(gnt_cnt);
      end
      g_num = g_num + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send(input int src, input int q, input int cls, input int cnt);
    @(negedge clk);
    req_valid = 1'b1;
    req_src   = 2'(src);
    req_queue = 3'(q);
    req_cls   = 1'(cls);
    req_cnt   = 4'(cnt);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    @(negedge clk);
    drain_valid = 1'b1;
    drain_cnt   = 5'(n);
    @(negedge clk);
    drain_valid = 1'b0;
  endtask

  task automatic set_bucket(input int rate, input int burst);
    @(negedge clk);
    cfg_rate  = 8'(rate);
    cfg_burst = 8'(burst);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check("R1 gnt_valid in reset", int'(gnt_valid), 0);
    rst = 1'b0;
    wait_cyc(2);
    check("R1 gnt_valid after reset", int'(gnt_valid), 0);

    // batch with mixed classes; tokens are zero so all wait
    send(1, 1, 1, 1);
    send(3, 3, 0, 1);
    send(0, 0, 1, 1);
    send(2, 2, 0, 1);
    send(0, 7, 0, 5);                       // R9: occupied source, ignored
    wait_cyc(3);
    check("R7 no grant without tokens", g_num, 0);
    set_bucket(16, 200);
    wait_cyc(20);
    check("R8 four grants", g_num, 4);
    check("R3 first grant class0 src2", g_src[0], 2);
    check("R3 second grant class0 src3", g_src[1], 3);
    check("R4 third grant src0", g_src[2], 0);
    check("R4 fourth grant src1", g_src[3], 1);
    check("R9 src0 queue kept", g_q[2], 0);
    check("R9 src0 count kept", g_cnt[2], 1);

    // round-robin wrap: class-1 pointer now at 2
    set_bucket(0, 0);
    wait_cyc(2);
    for (int s = 0; s < 4; s++) send(s, s + 4, 1, 1);
    wait_cyc(3);
    check("R7 burst zero blocks", g_num, 4);
    set_bucket(16, 200);
    wait_cyc(20);
    check("R4 wrap count", g_num, 8);
    check("R4 wrap order a", g_src[4], 2);
    check("R4 wrap order b", g_src[5], 3);
    check("R4 wrap order c", g_src[6], 0);
    check("R4 wrap order d", g_src[7], 1);

    // exact grant latency
    @(negedge clk);
    req_valid = 1'b1; req_src = 2'd1; req_queue = 3'd5; req_cls = 1'd0; req_cnt = 4'd3;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 not yet granted", int'(gnt_valid), 0);
    @(negedge clk);
    check("R2 grant valid", int'(gnt_valid), 1);
    check("R2 grant src", int'(gnt_src), 1);
    check("R2 grant queue", int'(gnt_queue), 5);
    check("R2 grant cnt", int'(gnt_cnt), 3);
    @(negedge clk);
    check("R8 single cycle strobe", int'(gnt_valid), 0);

    // reserved is 11; oversized drain clamps to zero
    drain(16);
    base = g_num;
    send(2, 1, 0, 15);
    wait_cyc(3);
    check("R6 clamp frees full buffer", g_num, base + 1);
    check("R6 count 15 granted", g_cnt[base], 15);

    // credit blocking and release
    drain(15);
    send(0, 2, 0, 10);
    wait_cyc(3);
    base = g_num;
    send(1, 3, 0, 8);
    wait_cyc(5);
    check("R5 blocked by credit", g_num, base);
    drain(2);
    wait_cyc(3);
    check("R5 granted after drain", g_num, base + 1);
    check("R5 granted src1", g_src[base], 1);
    check("R5 granted cnt8", g_cnt[base], 8);

    // strict priority under blocking: reserved 16, free 2 after drain
    drain(2);
    base = g_num;
    send(2, 4, 0, 4);
    send(3, 5, 1, 1);
    wait_cyc(5);
    check("R10 lower class held", g_num, base);
    drain(16);
    wait_cyc(5);
    check("R10 both granted", g_num, base + 2);
    check("R10 class0 first", g_src[base], 2);
    check("R10 class1 second", g_src[base + 1], 3);

    // zero count ignored
    drain(16);
    base = g_num;
    send(1, 1, 0, 0);
    wait_cyc(4);
    check("R9 zero count no grant", g_num, base);
    send(1, 6, 0, 2);
    wait_cyc(3);
    check("R9 entry still free", g_num, base + 1);
    check("R9 later request count", g_cnt[base], 2);

    // token rate and burst
    drain(16);
    set_bucket(0, 5);
    wait_cyc(2);
    base = g_num;
    send(0, 1, 0, 3);
    wait_cyc(3);
    check("R7 grant within burst", g_num, base + 1);
    send(1, 1, 0, 3);
    wait_cyc(12);
    check("R7 level 2 blocks 3", g_num, base + 1);
    set_bucket(1, 5);
    wait_cyc(20);
    check("R7 refill grants", g_num, base + 2);
    send(2, 1, 0, 6);
    wait_cyc(40);
    check("R7 burst ceiling blocks 6", g_num, base + 2);
    set_bucket(16, 200);
    wait_cyc(20);
    check("R7 raised ceiling grants", g_num, base + 3);
    check("R7 granted cnt6", g_cnt[base + 2], 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule